// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single DMA channel that takes its work from a linked list of descriptors held in memory, rather than from one address and length pair in registers. Software writes the address of the first descriptor and then sets the run bit. The channel then reads the six-word descriptor over a descriptor read port, copies the described bytes beat by beat over a word read/write port, and follows the descriptor's link word to the next entry. It stops when a link word equals a fixed end marker.

While a descriptor is in flight, the current source address, current destination address and remaining byte count are visible on output ports. A one-cycle pulse marks the completion of every descriptor that moved data, and a second pulse marks the end of the whole chain. A pause control freezes the transfer at the next burst boundary and keeps its progress. Clearing the run bit abandons the chain immediately. Both memory ports return read data exactly one cycle after the request.

Top module: `dchain_dma`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `run_o`, `desc_rd_o`, `data_rd_o`, `data_wr_o`, `pkg_done_o` and `chain_done_o` are all 0.
- R2: A write with `reg_sel`=0 stores the start address. A write with `reg_sel`=1 and `reg_wdata[0]`=1 while idle has two effects from the next cycle: `run_o` reads 1, and `desc_rd_o` is high with `desc_addr_o` equal to the start address.
- R3: A descriptor is fetched as six 32-bit words at the descriptor address plus 0, 4, 8, 12, 16 and 20. The words are, in that order: config, source address, destination address, byte count, a parameter word with no effect, and the link to the next descriptor. Config bits [15:0] describe the source side and bits [31:16] the destination side. Each half holds width in [1:0], burst in [3:2], address mode in [5:4] and a request type in [10:6] that has no effect.
- R4: Address mode 1 holds that side's address fixed for every beat. Any other code advances the address by the beat size after each beat.
- R5: The source width code 0/1/2/3 sets the beat to 1/2/4/8 bytes, and the destination uses the same beat size. The byte count is rounded down to a multiple of the beat size, and no bytes past the rounded count are written.
- R6: A descriptor whose rounded count is zero makes no data access and raises no `pkg_done_o`. The channel goes straight on to its link.
- R7: When the link word equals the end marker (default 0xFFFFF800), `chain_done_o` pulses once, `run_o` returns to 0 and no further descriptor read is made. Any other link value is fetched as the next descriptor.
- R8: `pkg_done_o` pulses once for every descriptor that moved data, in the cycle after its last write beat.
- R9: A write with `reg_sel`=1 and `reg_wdata[0]`=0 makes the following true from the next cycle: `run_o` is 0, no further memory access occurs, and neither done pulse is raised for the abandoned chain.
- R10: `reg_sel`=2 sets the pause bit from `reg_wdata[0]`. When the bit is set, the channel issues no new beat after the current burst of 1/4/8/16 beats (burst code 0/1/2/3) completes. A descriptor that has not begun any beat waits before its first beat. Clearing the bit resumes from the saved position.
- R11: `cur_src_o`, `cur_dst_o` and `left_o` show the current addresses and remaining rounded byte count of the active descriptor, including while it is paused.
- R12: A write of 1 to the run bit while the channel is already running has no effect on the chain in progress.
- R13: Each beat is a read cycle at the source address followed in the next cycle by a write at the destination address carrying that read's data. At most one of `desc_rd_o`, `data_rd_o` and `data_wr_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_sel | input | 2 | Register select: 0 start address, 1 run bit, 2 pause bit |
| reg_wdata | input | 32 | Control register write data |
| run_o | output | 1 | Run bit readback, 1 while the chain is active |
| cur_src_o | output | 32 | Current source address |
| cur_dst_o | output | 32 | Current destination address |
| left_o | output | 32 | Bytes remaining in the current descriptor |
| pkg_done_o | output | 1 | One-cycle pulse after each data-moving descriptor |
| chain_done_o | output | 1 | One-cycle pulse when the end marker is reached |
| desc_rd_o | output | 1 | Descriptor read request |
| desc_addr_o | output | 32 | Descriptor word byte address |
| desc_rdata_i | input | 32 | Descriptor read data, one cycle after the request |
| data_rd_o | output | 1 | Data beat read request |
| data_wr_o | output | 1 | Data beat write request |
| data_addr_o | output | 32 | Data beat byte address |
| data_size_o | output | 2 | Beat size code: bytes = 1 << code |
| data_wdata_o | output | DATA_W | Write data, beat in the low bytes |
| data_rdata_i | input | DATA_W | Read data, one cycle after the request, beat in the low bytes |

## Verification
The bench builds the channel with a 64-bit data port and the default end marker, so all four width codes can be reached, including the 8-byte beat. Odd and zero byte counts then exercise rounding across every beat size. Short chains of one to three descriptors mix linear and fixed addressing on each side. These chains also mix destination width codes that differ from the source, which shows that the beat size follows the source side. A 4-beat burst code makes the pause boundary land at a predictable beat count.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 6;

  // word positions inside one descriptor (software fixes this order)
  localparam int W_CFG  = 0;
  localparam int W_SRC  = 1;
  localparam int W_DST  = 2;
  localparam int W_CNT  = 3;
  localparam int W_PARA = 4;
  localparam int W_LINK = 5;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_RUN   = 2'd1;
  localparam logic [1:0] SEL_PAUSE = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_HOLD, ST_RD, ST_WR, ST_LINK
  } state_t;

  typedef struct packed {
    logic [4:0] req;
    logic [1:0] amode;
    logic [1:0] burst;
    logic [1:0] width;
  } side_cfg_t;

  function automatic side_cfg_t side_of(input logic [15:0] h);
    side_cfg_t s;
    s.width = h[1:0];
    s.burst = h[3:2];
    s.amode = h[5:4];
    s.req   = h[10:6];
    return s;
  endfunction

  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dchain_fetch.sv
module dchain_fetch
  import dchain_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                go,
  input  logic                                abort,
  input  logic [WORD_W-1:0]                   base,
  output logic                                desc_rd_o,
  output logic [WORD_W-1:0]                   desc_addr_o,
  input  logic [WORD_W-1:0]                   desc_rdata_i,
  output logic [DESC_WORDS-1:0][WORD_W-1:0]   words_o,
  output logic                                done_o
);

  localparam int IDX_W = $clog2(DESC_WORDS + 1);

  logic                              active_q;
  logic [IDX_W-1:0]                  idx_q;
  logic [WORD_W-1:0]                 base_q;
  logic [DESC_WORDS-1:0][WORD_W-1:0] words_q;
  logic                              done_q;

  // issue word idx, capture word idx-1 (one-cycle read latency)
  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst || abort) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      if (rst) begin
        base_q  <= '0;
        words_q <= '0;
      end
    end else if (go) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      base_q   <= base;
    end else if (active_q) begin
      idx_q <= idx_q + 1'b1;
      for (int k = 0; k < DESC_WORDS; k++)
        if (idx_q == IDX_W'(k + 1)) words_q[k] <= desc_rdata_i;
      if (idx_q == IDX_W'(DESC_WORDS)) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign desc_rd_o   = active_q && (idx_q < IDX_W'(DESC_WORDS));
  assign desc_addr_o = base_q + (WORD_W'(idx_q) << 2);
  assign words_o     = words_q;
  assign done_o      = done_q;

endmodule

// File: rtl/dchain_mover.sv
module dchain_mover
  import dchain_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   step,
  input  logic [1:0][WORD_W-1:0] ld_addr,   // [0] source, [1] destination
  input  logic [1:0]             ld_fix,    // per side: 1 = address held
  input  logic [WORD_W-1:0]      ld_bytes,
  input  logic [1:0]             ld_wcode,
  input  logic [1:0]             ld_burst,
  output logic [WORD_W-1:0]      cur_src_o,
  output logic [WORD_W-1:0]      cur_dst_o,
  output logic [WORD_W-1:0]      left_o,
  output logic [1:0]             wcode_o,
  output logic                   last_o,
  output logic                   bend_o
);

  logic [1:0][WORD_W-1:0] addr_q;
  logic [1:0]             fix_q;
  logic [1:0]             wcode_q;
  logic [WORD_W-1:0]      left_q;
  logic [4:0]             blen_q;
  logic [4:0]             bcnt_q;
  logic [WORD_W-1:0]      beat_bytes;

  assign beat_bytes = WORD_W'(1) << wcode_q;

  for (genvar s = 0; s < 2; s++) begin : g_side
    always_ff @(posedge clk) begin
      if (rst)                        addr_q[s] <= '0;
      else if (load)                  addr_q[s] <= ld_addr[s];
      else if (step && !fix_q[s])     addr_q[s] <= addr_q[s] + beat_bytes;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_q   <= '0;
      wcode_q <= '0;
      left_q  <= '0;
      blen_q  <= 5'd1;
      bcnt_q  <= '0;
    end else if (load) begin
      fix_q   <= ld_fix;
      wcode_q <= ld_wcode;
      left_q  <= ld_bytes;
      blen_q  <= burst_beats(ld_burst);
      bcnt_q  <= '0;
    end else if (step) begin
      left_q  <= left_q - beat_bytes;
      bcnt_q  <= bend_o ? 5'd0 : bcnt_q + 5'd1;
    end
  end

  assign cur_src_o = addr_q[0];
  assign cur_dst_o = addr_q[1];
  assign left_o    = left_q;
  assign wcode_o   = wcode_q;
  assign last_o    = (left_q == beat_bytes);
  assign bend_o    = (bcnt_q == blen_q - 5'd1);

endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
  import dchain_pkg::*;
#(
  parameter int          DATA_W   = 64,
  parameter logic [31:0] END_MARK = 32'hFFFF_F800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic              run_o,
  output logic [31:0]       cur_src_o,
  output logic [31:0]       cur_dst_o,
  output logic [31:0]       left_o,
  output logic              pkg_done_o,
  output logic              chain_done_o,
  output logic              desc_rd_o,
  output logic [31:0]       desc_addr_o,
  input  logic [31:0]       desc_rdata_i,
  output logic              data_rd_o,
  output logic              data_wr_o,
  output logic [31:0]       data_addr_o,
  output logic [1:0]        data_size_o,
  output logic [DATA_W-1:0] data_wdata_o,
  input  logic [DATA_W-1:0] data_rdata_i
);

  localparam int MAX_WCODE = $clog2(DATA_W / 8);

  state_t                            st_q, st_d;
  logic [WORD_W-1:0]                 start_q;
  logic                              pause_q;
  logic                              pkg_q, chain_q;
  logic [DESC_WORDS-1:0][WORD_W-1:0] words;
  logic                              fetch_done, fetch_go;
  logic [WORD_W-1:0]                 fetch_base;
  side_cfg_t                         src_cfg, dst_cfg;
  logic [1:0]                        wcode;
  logic [WORD_W-1:0]                 rounded;
  logic                              at_end, last, bend;
  logic                              run_wr, halt, launch;

  assign run_wr = reg_we && (reg_sel == SEL_RUN);
  assign halt   = run_wr && !reg_wdata[0];
  assign launch = run_wr && reg_wdata[0] && (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      pause_q <= 1'b0;
    end else if (reg_we) begin
      if (reg_sel == SEL_START) start_q <= reg_wdata;
      if (reg_sel == SEL_PAUSE) pause_q <= reg_wdata[0];
    end
  end

  // descriptor decode
  assign src_cfg = side_of(words[W_CFG][15:0]);
  assign dst_cfg = side_of(words[W_CFG][31:16]);
  assign wcode   = (src_cfg.width > 2'(MAX_WCODE)) ? 2'(MAX_WCODE) : src_cfg.width;
  assign rounded = words[W_CNT] & ~((WORD_W'(1) << wcode) - WORD_W'(1));
  assign at_end  = (words[W_LINK] == END_MARK);

  assign fetch_go   = launch || ((st_q == ST_LINK) && !at_end && !halt);
  assign fetch_base = (st_q == ST_LINK) ? words[W_LINK] : start_q;

  dchain_fetch u_fetch (
    .clk          (clk),
    .rst          (rst),
    .go           (fetch_go),
    .abort        (halt),
    .base         (fetch_base),
    .desc_rd_o    (desc_rd_o),
    .desc_addr_o  (desc_addr_o),
    .desc_rdata_i (desc_rdata_i),
    .words_o      (words),
    .done_o       (fetch_done)
  );

  dchain_mover u_mover (
    .clk       (clk),
    .rst       (rst),
    .load      (st_q == ST_DECODE),
    .step      (st_q == ST_WR),
    .ld_addr   ({words[W_DST], words[W_SRC]}),
    .ld_fix    ({dst_cfg.amode == 2'd1, src_cfg.amode == 2'd1}),
    .ld_bytes  (rounded),
    .ld_wcode  (wcode),
    .ld_burst  (src_cfg.burst),
    .cur_src_o (cur_src_o),
    .cur_dst_o (cur_dst_o),
    .left_o    (left_o),
    .wcode_o   (data_size_o),
    .last_o    (last),
    .bend_o    (bend)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (launch) st_d = ST_FETCH;
      ST_FETCH:  if (fetch_done) st_d = ST_DECODE;
      ST_DECODE: begin
        if (rounded == '0)  st_d = ST_LINK;
        else if (pause_q)   st_d = ST_HOLD;
        else                st_d = ST_RD;
      end
      ST_HOLD:   if (!pause_q) st_d = ST_RD;
      ST_RD:     st_d = ST_WR;
      ST_WR: begin
        if (last)                 st_d = ST_LINK;
        else if (bend && pause_q) st_d = ST_HOLD;
        else                      st_d = ST_RD;
      end
      ST_LINK:   st_d = at_end ? ST_IDLE : ST_FETCH;
      default:   st_d = ST_IDLE;
    endcase
    if (halt) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pkg_q   <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pkg_q   <= (st_q == ST_WR) && last && !halt;
      chain_q <= (st_q == ST_LINK) && at_end && !halt;
    end
  end

  assign run_o        = (st_q != ST_IDLE);
  assign pkg_done_o   = pkg_q;
  assign chain_done_o = chain_q;
  assign data_rd_o    = (st_q == ST_RD);
  assign data_wr_o    = (st_q == ST_WR);
  assign data_addr_o  = (st_q == ST_WR) ? cur_dst_o : cur_src_o;
  assign data_wdata_o = data_rdata_i;

  logic unused_fields;
  assign unused_fields = ^{words[W_PARA], words[W_CFG][15:11], words[W_CFG][31:27],
                           src_cfg.req, dst_cfg.req, dst_cfg.width, dst_cfg.burst,
                           reg_wdata[31:1]};

endmodule

// File: rtl/dchain_dma_chk.sv
module dchain_dma_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        run_o,
  input logic        pkg_done_o,
  input logic        chain_done_o,
  input logic        desc_rd_o,
  input logic        data_rd_o,
  input logic        data_wr_o
);

  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd1 && reg_wdata[0] && !run_o) |=> run_o); // R2

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd1 && !reg_wdata[0])
      |=> (!run_o && !desc_rd_o && !data_rd_o && !data_wr_o)); // R9

  AST_CHAIN_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    chain_done_o |-> !run_o); // R7

  AST_PKG_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    pkg_done_o |-> $past(data_wr_o)); // R8

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    data_wr_o |-> $past(data_rd_o)); // R13

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    $onehot0({desc_rd_o, data_rd_o, data_wr_o})); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_o |-> !(desc_rd_o || data_rd_o || data_wr_o)); // R1

endmodule

bind dchain_dma dchain_dma_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_we       (reg_we),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata),
  .run_o        (run_o),
  .pkg_done_o   (pkg_done_o),
  .chain_done_o (chain_done_o),
  .desc_rd_o    (desc_rd_o),
  .data_rd_o    (data_rd_o),
  .data_wr_o    (data_wr_o)
);

// File: tb/sim_dchain_dma.sv
`timescale 1ns/1ps
module sim_dchain_dma;

  localparam int          DW   = 64;
  localparam logic [31:0] ENDP = 32'hFFFF_F800;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic          run_o, pkg_done_o, chain_done_o;
  logic [31:0]   cur_src_o, cur_dst_o, left_o;
  logic          desc_rd_o, data_rd_o, data_wr_o;
  logic [31:0]   desc_addr_o, data_addr_o;
  logic [31:0]   desc_rdata = '0;
  logic [1:0]    data_size_o;
  logic [DW-1:0] data_wdata_o;
  logic [DW-1:0] data_rdata = '0;

  always #4 clk = ~clk;

  dchain_dma #(.DATA_W(DW), .END_MARK(ENDP)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .run_o(run_o), .cur_src_o(cur_src_o), .cur_dst_o(cur_dst_o), .left_o(left_o),
    .pkg_done_o(pkg_done_o), .chain_done_o(chain_done_o),
    .desc_rd_o(desc_rd_o), .desc_addr_o(desc_addr_o), .desc_rdata_i(desc_rdata),
    .data_rd_o(data_rd_o), .data_wr_o(data_wr_o), .data_addr_o(data_addr_o),
    .data_size_o(data_size_o), .data_wdata_o(data_wdata_o), .data_rdata_i(data_rdata)
  );

  logic [7:0] mem [0:4095];
  int n_chk = 0, n_fail = 0;
  int c_drd = 0, c_wr = 0, c_pkg = 0, c_chain = 0;

  // memory model: one-cycle read latency on both ports
  always @(posedge clk) begin
    if (desc_rd_o) begin
      c_drd = c_drd + 1;
      desc_rdata <= {mem[desc_addr_o[11:0] + 12'd3], mem[desc_addr_o[11:0] + 12'd2],
                     mem[desc_addr_o[11:0] + 12'd1], mem[desc_addr_o[11:0]]};
    end
    if (data_rd_o) begin
      logic [DW-1:0] v;
      v = '0;
      for (int i = 0; i < 8; i++)
        if (i < (1 << data_size_o)) v[i*8 +: 8] = mem[data_addr_o[11:0] + 12'(i)];
      data_rdata <= v;
    end
    if (data_wr_o) begin
      c_wr = c_wr + 1;
      for (int i = 0; i < 8; i++)
        if (i < (1 << data_size_o)) mem[data_addr_o[11:0] + 12'(i)] = data_wdata_o[i*8 +: 8];
    end
    if (pkg_done_o)   c_pkg   = c_pkg + 1;
    if (chain_done_o) c_chain = c_chain + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] side(input int w, input int b, input int m);
    return 16'((m << 4) | (b << 2) | w);
  endfunction

  task automatic put32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[i*8 +: 8];
  endtask

  task automatic mk_desc(input int a, input logic [31:0] cfg, input int s, input int d,
                         input int n, input logic [31:0] link);
    put32(a, cfg); put32(a + 4, s); put32(a + 8, d);
    put32(a + 12, n); put32(a + 16, 32'h5A5A_0000); put32(a + 20, link);
  endtask

  function automatic logic [7:0] src_byte(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic prep_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    for (int i = 0; i < 1024; i++) mem[1024 + i] = src_byte(i);
    for (int i = 2048; i < 4096; i++) mem[i] = 8'hEE;
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic start_chain(input int a);
    reg_write(2'd0, a);
    reg_write(2'd1, 32'd1);
  endtask

  task automatic wait_chain(input int base, input string req);
    int i;
    for (i = 0; i < 5000; i++) begin
      if (c_chain > base) break;
      @(negedge clk);
    end
    check(req, (i < 5000), 1'b1);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_copy(input string req, input int d, input int s, input int n);
    for (int i = 0; i < n; i++) check(req, mem[d + i], mem[s + i]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 run", run_o, 0);
    check("R1 access", {desc_rd_o, data_rd_o, data_wr_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {run_o, desc_rd_o, data_rd_o, data_wr_o, pkg_done_o, chain_done_o}, 0);
  endtask

  task automatic t_single();
    int d0 = c_drd, w0 = c_wr, p0 = c_pkg, ch0 = c_chain;
    prep_mem();
    mk_desc(32'h100, {side(2,0,0), side(2,0,0)}, 32'h400, 32'h800, 16, ENDP);
    start_chain(32'h100);
    check("R2 run readback", run_o, 1);
    check("R2 first fetch", {desc_rd_o, desc_addr_o}, {1'b1, 32'h100});
    wait_chain(ch0, "R7 chain end");
    chk_copy("R13 copy", 32'h800, 32'h400, 16);
    check("R5 no overrun", mem[32'h810], 8'hEE);
    check("R5 beat count", c_wr - w0, 4);
    check("R8 pkg pulses", c_pkg - p0, 1);
    check("R7 chain pulses", c_chain - ch0, 1);
    check("R7 run cleared", run_o, 0);
    repeat (10) @(negedge clk);
    check("R3 six word fetch, R7 no refetch", c_drd - d0, 6);
    check("R11 final src", cur_src_o, 32'h410);
    check("R11 final dst", cur_dst_o, 32'h810);
    check("R11 final left", left_o, 0);
  endtask

  task automatic t_chain();
    int d0 = c_drd, w0 = c_wr, p0 = c_pkg, ch0 = c_chain;
    prep_mem();
    mk_desc(32'h100, {side(0,0,0), side(0,0,0)}, 32'h400, 32'h800, 5, 32'h140);
    mk_desc(32'h140, {side(0,0,0), side(1,0,0)}, 32'h410, 32'h820, 7, 32'h180);
    mk_desc(32'h180, {side(3,0,0), side(3,0,0)}, 32'h440, 32'h840, 16, ENDP);
    start_chain(32'h100);
    repeat (6) @(negedge clk);
    reg_write(2'd0, 32'h180);
    reg_write(2'd1, 32'd1);   // R12: must not restart
    wait_chain(ch0, "R7 chain end");
    chk_copy("R5 8-bit", 32'h800, 32'h400, 5);
    check("R5 8-bit tail", mem[32'h805], 8'hEE);
    chk_copy("R5 16-bit rounded", 32'h820, 32'h410, 6);
    check("R5 rounded tail", mem[32'h826], 8'hEE);
    chk_copy("R5 64-bit", 32'h840, 32'h440, 16);
    check("R5 beats", c_wr - w0, 10);
    check("R8 pkg pulses", c_pkg - p0, 3);
    check("R12 descriptor reads", c_drd - d0, 18);
    check("R12 chain pulses", c_chain - ch0, 1);
  endtask

  task automatic t_fixed();
    int ch0 = c_chain;
    prep_mem();
    mk_desc(32'h100, {side(2,0,0), side(2,0,1)}, 32'h400, 32'h800, 12, 32'h140);
    mk_desc(32'h140, {side(2,0,1), side(2,0,0)}, 32'h410, 32'h860, 8, ENDP);
    start_chain(32'h100);
    wait_chain(ch0, "R4 chain end");
    for (int k = 0; k < 3; k++) chk_copy("R4 fixed source", 32'h800 + 4*k, 32'h400, 4);
    chk_copy("R4 fixed dest last beat", 32'h860, 32'h414, 4);
    check("R4 fixed dest tail", mem[32'h864], 8'hEE);
    check("R4 dest held", cur_dst_o, 32'h860);
    check("R4 source advanced", cur_src_o, 32'h418);
  endtask

  task automatic t_zero();
    int d0 = c_drd, w0 = c_wr, p0 = c_pkg, ch0 = c_chain;
    prep_mem();
    mk_desc(32'h100, {side(0,0,0), side(0,0,0)}, 32'h400, 32'h800, 0, 32'h140);
    mk_desc(32'h140, {side(2,0,0), side(2,0,0)}, 32'h400, 32'h800, 2, 32'h180);
    mk_desc(32'h180, {side(0,0,0), side(0,0,0)}, 32'h420, 32'h880, 4, ENDP);
    start_chain(32'h100);
    wait_chain(ch0, "R6 chain end");
    check("R6 skipped dest", mem[32'h800], 8'hEE);
    check("R6 skipped dest rounded", mem[32'h803], 8'hEE);
    chk_copy("R6 last copy", 32'h880, 32'h420, 4);
    check("R6 writes", c_wr - w0, 4);
    check("R6 pkg pulses", c_pkg - p0, 1);
    check("R6 descriptor reads", c_drd - d0, 18);
  endtask

  task automatic t_halt();
    int w0 = c_wr, p0 = c_pkg, ch0 = c_chain, w1, d1;
    prep_mem();
    mk_desc(32'h100, {side(0,0,0), side(0,0,0)}, 32'h400, 32'h900, 200, ENDP);
    start_chain(32'h100);
    while (c_wr - w0 < 10) @(negedge clk);
    reg_write(2'd1, 32'd0);
    check("R9 run cleared", run_o, 0);
    w1 = c_wr; d1 = c_drd;
    repeat (50) @(negedge clk);
    check("R9 no more writes", c_wr, w1);
    check("R9 no more fetches", c_drd, d1);
    check("R9 no pkg", c_pkg - p0, 0);
    check("R9 no chain", c_chain - ch0, 0);
    check("R9 tail untouched", mem[32'h900 + 199], 8'hEE);
  endtask

  task automatic t_pause();
    int w0, ch0;
    prep_mem();
    // pause mid burst: stop at the 4-beat boundary
    mk_desc(32'h100, {side(0,0,0), side(0,1,0)}, 32'h400, 32'hA00, 32, ENDP);
    w0 = c_wr; ch0 = c_chain;
    start_chain(32'h100);
    while (c_wr - w0 < 2) @(negedge clk);
    reg_write(2'd2, 32'd1);
    repeat (40) @(negedge clk);
    check("R10 burst boundary", c_wr - w0, 4);
    check("R10 still running", run_o, 1);
    check("R11 left while paused", left_o, 28);
    check("R11 src while paused", cur_src_o, 32'h404);
    check("R11 dst while paused", cur_dst_o, 32'hA04);
    reg_write(2'd2, 32'd0);
    wait_chain(ch0, "R10 resume end");
    chk_copy("R10 resumed copy", 32'hA00, 32'h400, 32);
    // pause before the first beat
    mk_desc(32'h140, {side(0,0,0), side(0,1,0)}, 32'h400, 32'hA40, 32, ENDP);
    reg_write(2'd2, 32'd1);
    w0 = c_wr; ch0 = c_chain;
    start_chain(32'h140);
    repeat (30) @(negedge clk);
    check("R10 no beat before start", c_wr - w0, 0);
    check("R11 loaded left", left_o, 32);
    check("R11 loaded src", cur_src_o, 32'h400);
    reg_write(2'd2, 32'd0);
    wait_chain(ch0, "R10 second end");
    chk_copy("R10 second copy", 32'hA40, 32'h400, 32);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog R7 chain never ended");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_chain();
    t_fixed();
    t_zero();
    t_halt();
    t_pause();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule